// File: doc/BRIEF.md
# Trace Packet Address Translator

This block takes a byte stream of compact trace packets from a capture front end and turns each packet into a single sized write on a memory-write port. Every packet begins with a three-byte header that selects one of four destination windows, gives a status code and a write width, and supplies an 18-bit offset. The payload that follows is exactly as long as the width says. The block checks the offset against the selected window's region size. When the offset is inside the window, it adds the window's 32-bit base to the offset and issues the write. When it is not, the packet is dropped.

Software programs a base and a region size for each window through a small register port. Software also reads a status word from that port. The status word holds two sticky flags, one for a transmitter overflow and one for an out-of-window packet, along with the selector of the most recent rejected packet. Each flag is cleared by writing one to its bit. Byte acceptance stalls while a write waits for its handshake, so the upstream source sees back-pressure through the input ready signal.

Top module: `trace_xlate`

## Requirements
- R1: Header byte order: the first byte carries the selector in bits 7:6, the status in bits 5:4, the width code in bits 3:2 and offset bits 17:16 in bits 1:0. The second byte holds offset bits 15:8 and the third byte holds offset bits 7:0.
- R2: After the header, the block takes 1, 2, 4 or 8 payload bytes for width codes 0, 1, 2 and 3. The first payload byte lands in data bits 7:0. The byte after the last payload byte is the first header byte of the next packet.
- R3: Selector n uses window n. Register address 2n holds the window's 32-bit base. Register address 2n+1 holds its 19-bit region size, read back zero-extended.
- R4: A packet whose offset is below the selected region size produces one write to address base plus offset, taken modulo 2^32.
- R5: A packet whose offset is equal to or above the region size produces no write. It sets the error flag (status bit 1) and stores its selector in status bits 3:2.
- R6: Status code 3 sets the overflow flag (status bit 0) whether or not the packet is written. Status codes 0, 1 and 2 have no effect on any flag.
- R7: wr_valid rises in the cycle after the last payload byte is accepted. wr_be is 0x01, 0x03, 0x0F or 0xFF for width codes 0 to 3, and data outside the enabled bytes is zero. Address, data and enables stay unchanged until a cycle in which wr_ready is high.
- R8: in_ready is low exactly while a write is pending, and no byte is taken in that time.
- R9: Writing to register address 8 clears each flag whose bit in the write data is one. If a packet sets a flag in the same cycle as the clear, the flag stays set. Addresses above 8 read as zero.
- R10: A synchronous reset clears every base and size register, both flags, the stored selector, any pending write and any partly assembled packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Packet byte available |
| in_byte | input | 8 | Packet byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from cfg_addr |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Write accepted when high together with wr_valid |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 64 | Write data, zero above the enabled bytes |
| wr_be | output | 8 | Byte enables |

## Verification
The bench sends packets of every width to every window. Offsets sit at zero, at size minus one, at the size itself and at the top of the 18-bit range, which separates off-by-one faults in the window check. A base near the top of the address space shows whether the sum wraps. Packets are sent back to back while the write handshake is stalled on two of every three cycles, which shows whether requests are held and bytes are correctly refused. Status codes 2 and 3 are sent into accepted and rejected packets, and a flag clear is placed on the same cycle as a packet that sets the flag, to check overflow, error and clear precedence apart.

// File: rtl/trace_xlate_pkg.sv
package trace_xlate_pkg;

  localparam int OFS_W     = 18;
  localparam int HDR_BYTES = 3;
  localparam int MAX_BYTES = 8;
  localparam int HDR_W     = 8 * HDR_BYTES;
  localparam int DATA_W    = 8 * MAX_BYTES;
  localparam int LIM_W     = OFS_W + 1;

  localparam logic [1:0] STAT_OVF = 2'b11;

  typedef struct packed {
    logic [1:0]       dest;
    logic [1:0]       stat;
    logic [1:0]       size;
    logic [OFS_W-1:0] ofs;
  } hdr_t;

  // number of payload bytes for a width code
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // byte-enable pattern for a width code
  function automatic logic [MAX_BYTES-1:0] size_be(input logic [1:0] code);
    logic [MAX_BYTES-1:0] be;
    case (code)
      2'd0:    be = 8'h01;
      2'd1:    be = 8'h03;
      2'd2:    be = 8'h0F;
      default: be = 8'hFF;
    endcase
    return be;
  endfunction

  // window test: offset strictly below region size
  function automatic logic offset_fits(input logic [OFS_W-1:0] ofs,
                                       input logic [LIM_W-1:0] lim);
    return {1'b0, ofs} < lim;
  endfunction

endpackage

// File: rtl/trace_rx.sv
module trace_rx
  import trace_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              accept,
  output logic              done,
  output hdr_t              hdr,
  output logic [DATA_W-1:0] payload
);

  localparam int CNT_W  = $clog2(HDR_BYTES + MAX_BYTES + 1);
  localparam int PIDX_W = $clog2(MAX_BYTES);

  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] data_q;
  logic              take;
  logic              in_hdr;
  logic              last;
  logic [PIDX_W-1:0] pidx;

  assign take   = in_valid && accept;
  assign in_hdr = cnt_q < CNT_W'(HDR_BYTES);
  assign pidx   = PIDX_W'(cnt_q - CNT_W'(HDR_BYTES));
  assign hdr    = hdr_t'(hdr_q);
  assign last   = !in_hdr && ({1'b0, pidx} == (size_bytes(hdr.size) - 4'd1));
  assign done   = take && last;

  // payload as seen with the incoming byte placed in its lane
  always_comb begin
    payload = data_q;
    if (!in_hdr) payload[8*pidx +: 8] = in_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hdr_q  <= '0;
      data_q <= '0;
    end else if (take) begin
      if (last) begin
        cnt_q  <= '0;
        data_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (in_hdr) hdr_q <= {hdr_q[HDR_W-9:0], in_byte};
        else        data_q[8*pidx +: 8] <= in_byte;
      end
    end
  end

endmodule

// File: rtl/trace_regs.sv
module trace_regs
  import trace_xlate_pkg::*;
#(
  parameter int DEST_N = 4,
  parameter int BUS_AW = 32,
  parameter int CFG_AW = 4,
  localparam int DEST_W = $clog2(DEST_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [DEST_W-1:0] sel_dest,
  output logic [BUS_AW-1:0] sel_base,
  output logic [LIM_W-1:0]  sel_lim,
  input  logic              set_ovf,
  input  logic              set_err,
  input  logic [DEST_W-1:0] err_dest_in,
  output logic              ovf_flag,
  output logic              err_flag
);

  localparam int STAT_IDX = 2 * DEST_N;

  logic [DEST_N-1:0][BUS_AW-1:0] base_q;
  logic [DEST_N-1:0][LIM_W-1:0]  lim_q;
  logic [DEST_N-1:0]             hit_base;
  logic [DEST_N-1:0]             hit_lim;
  logic                          hit_stat;
  logic [DEST_W-1:0]             err_dest_q;

  for (genvar g = 0; g < DEST_N; g++) begin : g_dec
    assign hit_base[g] = cfg_wr && (cfg_addr == CFG_AW'(2 * g));
    assign hit_lim[g]  = cfg_wr && (cfg_addr == CFG_AW'(2 * g + 1));
  end
  assign hit_stat = cfg_wr && (cfg_addr == CFG_AW'(STAT_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      lim_q  <= '0;
    end else begin
      for (int i = 0; i < DEST_N; i++) begin
        if (hit_base[i]) base_q[i] <= cfg_wdata[BUS_AW-1:0];
        if (hit_lim[i])  lim_q[i]  <= cfg_wdata[LIM_W-1:0];
      end
    end
  end

  // sticky flags: a set in the same cycle outranks a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag   <= 1'b0;
      err_flag   <= 1'b0;
      err_dest_q <= '0;
    end else begin
      if (set_ovf)                        ovf_flag <= 1'b1;
      else if (hit_stat && cfg_wdata[0])  ovf_flag <= 1'b0;
      if (set_err)                        err_flag <= 1'b1;
      else if (hit_stat && cfg_wdata[1])  err_flag <= 1'b0;
      if (set_err)                        err_dest_q <= err_dest_in;
    end
  end

  assign sel_base = base_q[sel_dest];
  assign sel_lim  = lim_q[sel_dest];

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < DEST_N; i++) begin
      if (cfg_addr == CFG_AW'(2 * i))     cfg_rdata = 32'(base_q[i]);
      if (cfg_addr == CFG_AW'(2 * i + 1)) cfg_rdata = 32'(lim_q[i]);
    end
    if (cfg_addr == CFG_AW'(STAT_IDX))
      cfg_rdata = 32'({err_dest_q, err_flag, ovf_flag});
  end

endmodule

// File: rtl/trace_wport.sv
module trace_wport
  import trace_xlate_pkg::*;
#(
  parameter int BUS_AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [BUS_AW-1:0]    ld_addr,
  input  logic [DATA_W-1:0]    ld_data,
  input  logic [MAX_BYTES-1:0] ld_be,
  input  logic                 wr_ready,
  output logic                 wr_valid,
  output logic [BUS_AW-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic [MAX_BYTES-1:0] wr_be
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_be    <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= ld_addr;
      wr_data  <= ld_data;
      wr_be    <= ld_be;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/trace_xlate.sv
module trace_xlate
  import trace_xlate_pkg::*;
#(
  parameter int DEST_N = 4,
  parameter int BUS_AW = 32,
  parameter int CFG_AW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [7:0]           in_byte,
  output logic                 in_ready,
  input  logic                 cfg_wr,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [BUS_AW-1:0]    wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic [MAX_BYTES-1:0] wr_be
);

  localparam int DEST_W = $clog2(DEST_N);

  hdr_t              pkt_hdr;
  logic [DATA_W-1:0] pkt_data;
  logic              pkt_done;
  logic [BUS_AW-1:0] sel_base;
  logic [LIM_W-1:0]  sel_lim;
  logic              in_win;
  logic              write_evt;
  logic              drop_evt;
  logic              ovf_evt;
  logic              ovf_flag;
  logic              err_flag;
  logic [BUS_AW-1:0] dest_addr;

  assign in_ready = !wr_valid;

  trace_rx u_rx (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .in_byte (in_byte),
    .accept  (in_ready),
    .done    (pkt_done),
    .hdr     (pkt_hdr),
    .payload (pkt_data)
  );

  trace_regs #(
    .DEST_N(DEST_N),
    .BUS_AW(BUS_AW),
    .CFG_AW(CFG_AW)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .sel_dest   (DEST_W'(pkt_hdr.dest)),
    .sel_base   (sel_base),
    .sel_lim    (sel_lim),
    .set_ovf    (ovf_evt),
    .set_err    (drop_evt),
    .err_dest_in(DEST_W'(pkt_hdr.dest)),
    .ovf_flag   (ovf_flag),
    .err_flag   (err_flag)
  );

  assign in_win    = offset_fits(pkt_hdr.ofs, sel_lim);
  assign write_evt = pkt_done && in_win;
  assign drop_evt  = pkt_done && !in_win;
  assign ovf_evt   = pkt_done && (pkt_hdr.stat == STAT_OVF);
  assign dest_addr = sel_base + BUS_AW'(pkt_hdr.ofs);

  trace_wport #(
    .BUS_AW(BUS_AW)
  ) u_wport (
    .clk     (clk),
    .rst     (rst),
    .load    (write_evt),
    .ld_addr (dest_addr),
    .ld_data (pkt_data),
    .ld_be   (size_be(pkt_hdr.size)),
    .wr_ready(wr_ready),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_be   (wr_be)
  );

endmodule

// File: rtl/trace_xlate_chk.sv
module trace_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [63:0] wr_data,
  input logic [7:0]  wr_be,
  input logic        write_evt,
  input logic        drop_evt,
  input logic        ovf_evt,
  input logic        ovf_flag,
  input logic        err_flag
);

  function automatic logic [63:0] lane_mask(input logic [7:0] be);
    logic [63:0] m;
    for (int i = 0; i < 8; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be));

  assert_be_legal_R7: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_be == 8'h01 || wr_be == 8'h03 || wr_be == 8'h0F || wr_be == 8'hFF));

  assert_zero_ext_R7: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ((wr_data & ~lane_mask(wr_be)) == 64'd0));

  assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !in_ready);

  assert_issue_R4: assert property (@(posedge clk) disable iff (rst)
    write_evt |=> wr_valid);

  assert_drop_R5: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> err_flag && !wr_valid);

  assert_ovf_R6: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf_flag);

endmodule

bind trace_xlate trace_xlate_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .wr_be    (wr_be),
  .write_evt(write_evt),
  .drop_evt (drop_evt),
  .ovf_evt  (ovf_evt),
  .ovf_flag (ovf_flag),
  .err_flag (err_flag)
);

// File: tb/tb_trace_xlate.sv
`timescale 1ns/1ps
module tb_trace_xlate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = 4'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_be;

  int checks = 0;
  int errors = 0;
  int stall_mode = 0;
  int cyc = 0;
  int writes_seen = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  trace_xlate dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0]  q[$];
  logic [31:0] m_base [4];
  logic [18:0] m_lim  [4];
  bit          m_ovf, m_err, m_pend;
  logic [1:0]  m_edest;
  logic [31:0] m_addr;
  logic [63:0] m_data;
  logic [7:0]  m_be;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      q.delete();
      for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_lim[i] = 0; end
      m_ovf = 0; m_err = 0; m_pend = 0; m_edest = 0;
    end else begin
      bit took, fin, hit, setov, seter;
      int n;
      logic [1:0] d;
      logic [17:0] ofs;
      logic [31:0] na;
      logic [63:0] nd;
      took = in_valid && !m_pend;
      fin = 0; hit = 0; setov = 0; seter = 0;
      if (m_pend && wr_ready) m_pend = 0;
      if (took) begin
        q.push_back(in_byte);
        if (q.size() >= 3) begin
          n = 1 << q[0][3:2];
          if (q.size() == 3 + n) fin = 1;
        end
      end
      if (fin) begin
        d   = q[0][7:6];
        ofs = {q[0][1:0], q[1], q[2]};
        nd  = 0;
        for (int i = 0; i < n; i++) nd |= 64'(q[3+i]) << (8*i);
        hit = (int'(ofs) < int'(m_lim[d]));
        na  = m_base[d] + 32'(ofs);
        setov = (q[0][5:4] == 2'b11);
        seter = !hit;
        if (hit) begin
          m_pend = 1; m_addr = na; m_data = nd; m_be = 8'((1 << n) - 1);
        end
        if (seter) m_edest = d;
        q.delete();
      end
      if (cfg_wr) begin
        if (cfg_addr < 8) begin
          if (cfg_addr[0]) m_lim[cfg_addr[2:1]] = cfg_wdata[18:0];
          else             m_base[cfg_addr[2:1]] = cfg_wdata;
        end else if (cfg_addr == 8) begin
          if (cfg_wdata[0]) m_ovf = 0;
          if (cfg_wdata[1]) m_err = 0;
        end
      end
      if (setov) m_ovf = 1;
      if (seter) m_err = 1;
    end
  end

  function automatic logic [31:0] model_read(input logic [3:0] a);
    if (a < 8) return a[0] ? 32'(m_lim[a[2:1]]) : m_base[a[2:1]];
    if (a == 8) return 32'({m_edest, m_err, m_ovf});
    return 32'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      check(in_ready === !m_pend, "R8 in_ready", 64'(in_ready), 64'(!m_pend));
      check(wr_valid === m_pend, "R7 wr_valid", 64'(wr_valid), 64'(m_pend));
      if (m_pend && wr_valid) begin
        check(wr_addr === m_addr, "R1/R4 wr_addr", 64'(wr_addr), 64'(m_addr));
        check(wr_data === m_data, "R2/R7 wr_data", wr_data, m_data);
        check(wr_be === m_be, "R7 wr_be", 64'(wr_be), 64'(m_be));
        if (wr_ready) writes_seen++;
      end
      check(cfg_rdata === model_read(cfg_addr),
            (cfg_addr < 8) ? "R3 cfg_rdata" : "R9 cfg_rdata",
            64'(cfg_rdata), 64'(model_read(cfg_addr)));
    end
  end

  always @(negedge clk) wr_ready <= (stall_mode != 0) ? ((cyc % 3) == 2) : 1'b1;

  // ---------------- stimulus tasks ----------------
  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a;
    #1;
    check(cfg_rdata === exp, tag, 64'(cfg_rdata), 64'(exp));
    @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    bit t;
    in_valid = 1; in_byte = b;
    forever begin
      t = in_ready;
      @(negedge clk);
      if (t) break;
    end
  endtask

  task automatic send(input logic [1:0] d, input logic [1:0] st, input logic [1:0] sz,
                      input logic [17:0] ofs, input logic [63:0] data, input bit idle_after,
                      input logic [1:0] clr_on_last);
    int n;
    n = 1 << sz;
    put_byte({d, st, sz, ofs[17:16]});
    put_byte(ofs[15:8]);
    put_byte(ofs[7:0]);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1 && clr_on_last != 0) begin
        cfg_wr = 1; cfg_addr = 4'd8; cfg_wdata = 32'(clr_on_last);
      end
      put_byte(data[8*i +: 8]);
    end
    cfg_wr = 0;
    if (idle_after) in_valid = 0;
  endtask

  task automatic drain();
    while (wr_valid || in_valid) begin
      in_valid = 0;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int w0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R10: reset state of registers and ports
    for (int a = 0; a <= 8; a++) expect_reg(4'(a), 32'd0, "R10 reset reg");
    check(in_ready === 1'b1, "R10 in_ready after reset", 64'(in_ready), 64'd1);
    check(wr_valid === 1'b0, "R10 wr_valid after reset", 64'(wr_valid), 64'd0);

    // R3: window programming
    cfg_write(4'd0, 32'h1000_0000); cfg_write(4'd1, 32'h0000_0100);
    cfg_write(4'd2, 32'h2000_0000); cfg_write(4'd3, 32'h0004_0000);
    cfg_write(4'd4, 32'hFFFF_FFF0); cfg_write(4'd5, 32'h0000_0080);
    cfg_write(4'd6, 32'h0000_8000); cfg_write(4'd7, 32'h0000_0000);
    expect_reg(4'd4, 32'hFFFF_FFF0, "R3 base2");
    expect_reg(4'd3, 32'h0004_0000, "R3 size1");
    cfg_write(4'd5, 32'hFFFF_FFFF);
    expect_reg(4'd5, 32'h0007_FFFF, "R3 size 19-bit");
    cfg_write(4'd5, 32'h0000_0080);
    expect_reg(4'd12, 32'd0, "R9 unused address");

    // R1 R2 R4 R7: every width, every in-range window
    w0 = writes_seen;
    send(2'd0, 2'd0, 2'd0, 18'h00010, 64'hFFFF_FFFF_FFFF_FFAB, 1, 0);
    send(2'd1, 2'd1, 2'd1, 18'h3FFFF, 64'h0000_0000_0000_1234, 1, 0);
    send(2'd0, 2'd2, 2'd2, 18'h000FF, 64'h0000_0000_DEAD_BEEF, 1, 0);
    send(2'd2, 2'd0, 2'd3, 18'h00020, 64'h0123_4567_89AB_CDEF, 1, 0);
    send(2'd1, 2'd0, 2'd0, 18'h00000, 64'h0000_0000_0000_005A, 1, 0);
    drain();
    check(writes_seen - w0 == 5, "R4 writes issued", 64'(writes_seen - w0), 64'd5);
    expect_reg(4'd8, 32'd0, "R6 status codes 0-2 leave flags");

    // R5: offset equal to size, and a zero-size window
    w0 = writes_seen;
    send(2'd0, 2'd0, 2'd1, 18'h00100, 64'h0000_0000_0000_7777, 1, 0);
    drain();
    expect_reg(4'd8, 32'h0000_0002, "R5 error flag dest0");
    send(2'd3, 2'd2, 2'd0, 18'h00000, 64'h0000_0000_0000_0011, 1, 0);
    drain();
    check(writes_seen == w0, "R5 no write", 64'(writes_seen), 64'(w0));
    expect_reg(4'd8, 32'h0000_000E, "R5 error flag dest3");

    // R9: clear error flag, selector retained
    cfg_write(4'd8, 32'h0000_0002);
    expect_reg(4'd8, 32'h0000_000C, "R9 clear err");

    // R6: overflow code, in-range and out-of-range
    w0 = writes_seen;
    send(2'd1, 2'd3, 2'd2, 18'h00004, 64'h0000_0000_CAFE_F00D, 1, 0);
    drain();
    check(writes_seen - w0 == 1, "R6 overflow packet still written", 64'(writes_seen - w0), 64'd1);
    expect_reg(4'd8, 32'h0000_000D, "R6 overflow flag");
    cfg_write(4'd8, 32'h0000_0001);
    send(2'd2, 2'd3, 2'd0, 18'h00080, 64'h0000_0000_0000_0042, 1, 0);
    drain();
    expect_reg(4'd8, 32'h0000_000B, "R6 overflow with drop");

    // R9: clear in same cycle as a set; set wins
    cfg_write(4'd8, 32'h0000_0003);
    send(2'd0, 2'd3, 2'd0, 18'h00001, 64'h0000_0000_0000_0099, 1, 2'b01);
    drain();
    expect_reg(4'd8, 32'h0000_0009, "R9 set beats clear");
    cfg_write(4'd8, 32'h0000_0003);
    expect_reg(4'd8, 32'h0000_0008, "R9 both cleared");

    // R7 R8: back-to-back packets with a stalled write port
    stall_mode = 1;
    w0 = writes_seen;
    for (int k = 0; k < 12; k++)
      send(2'(k), 2'(k % 3), 2'(k % 4), 18'(k * 7), {8{8'(k + 8'h31)}}, 0, 0);
    drain();
    check(writes_seen - w0 == 9, "R8 stalled writes", 64'(writes_seen - w0), 64'd9);
    stall_mode = 0;
    @(negedge clk);

    // R10: reset in the middle of a packet
    put_byte(8'h08);
    put_byte(8'h00);
    in_valid = 0;
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    expect_reg(4'd0, 32'd0, "R10 base cleared");
    expect_reg(4'd1, 32'd0, "R10 size cleared");
    expect_reg(4'd8, 32'd0, "R10 flags cleared");
    cfg_write(4'd1, 32'h0000_0010);
    w0 = writes_seen;
    send(2'd0, 2'd0, 2'd0, 18'h00003, 64'h0000_0000_0000_00C3, 1, 0);
    drain();
    check(writes_seen - w0 == 1, "R10 assembly restarted", 64'(writes_seen - w0), 64'd1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule